// File: doc/BRIEF.md
# PWM Timebase Counter with Edge and Center Alignment

This block is the timebase behind a pulse-width modulator. A 16-bit counter advances on ticks taken from the module clock. A 3-bit select divides the clock by a power of two. An enable can add a further fixed divide-by-256 stage. The counter runs in one of two modes:

- **Edge-aligned:** it ramps up, then drops back to zero after it reaches the active period.
- **Center-aligned:** it climbs to the period, turns, and descends until it passes through one.

A direction flag shows which way the counter is moving. A pulse marks every tick at which the count equals the active period.

The period is written into a shadow register. The shadow is copied into the active period only when the transfer enable in the control word is set, and only at the period boundary. After the copy, the enable clears itself. This lets a new period be staged at any time without disturbing the cycle that is in progress.

The control word is written with a one-cycle strobe and can be read back at any time. The shadow is also written with a one-cycle strobe. Both writes are always accepted, so there is no back-pressure at either write port.

Top module: `pwm_timer_core`

## Requirements
- R1: After reset the block is in this state:
  - the count is 0 and the direction is 0 (up);
  - the control word reads 0, so the timer is stopped;
  - the active period is 0xFFFF;
  - the match pulse is low.
- R2: A write with `ctrl_wr_i` high loads `ctrl_wdata_i` into the control word, which reads back on `ctrl_o`. The bit fields are:
  - bits [2:0]: clock select;
  - bit 3: divide-by-256 enable;
  - bit 4: run;
  - bit 5: shadow-transfer enable;
  - bit 6: mode, where 0 is edge-aligned and 1 is center-aligned.
- R3: While running, ticks come every 2^select module clocks. With bit 3 set, ticks come every 256 * 2^select module clocks.
- R4: While run is 0, the count and the direction hold, and no tick occurs.
- R5: In edge-aligned mode each tick behaves as follows:
  - the count rises by one;
  - a tick at count == period sets the count to 0 instead;
  - the direction reads 0.
- R6: In center-aligned mode each tick behaves as follows:
  - while counting up, the count rises by one;
  - a tick at count == period (period >= 1) loads period-1 and sets the direction to 1;
  - while counting down, the count falls by one;
  - a tick at count <= 1 while counting down loads 0 and sets the direction back to 0.
- R7: `pmatch_o` is high exactly in a cycle that carries a tick while the count equals the active period.
- R8: A shadow write changes only the shadow. The active period takes the shadow value only at a period boundary, and only while bit 5 is set. In edge-aligned mode the boundary is the wrap to 0. In center-aligned mode it is the turn from down to up.
- R9: On the edge where a transfer happens, bit 5 of the control word clears. A control write on that same edge takes priority over the clear.
- R10: A write that changes bits [3:0] restarts the divider, so the next tick lands 2^(total shift) clocks after the write edge. A write that leaves bits [3:0] unchanged keeps the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | module clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ctrl_wr_i | input | 1 | control word write strobe |
| ctrl_wdata_i | input | 7 | new control word |
| ctrl_o | output | 7 | current control word, including the self-clearing transfer bit |
| per_wr_i | input | 1 | period shadow write strobe |
| per_wdata_i | input | 16 | new period shadow value |
| per_act_o | output | 16 | active period |
| cnt_o | output | 16 | counter value |
| dir_o | output | 1 | count direction, 1 = down |
| pmatch_o | output | 1 | period match pulse |

## Verification
The hardest state to reach from the ports is the first period transfer after reset. The active period starts at 0xFFFF, so the first boundary comes only after the counter has climbed through its whole range. The stimulus runs at divide-by-1 with a shadow value and the transfer enable staged, then waits out that long first ramp. After that, a short period makes boundaries frequent. A second transfer is staged while the counter is in center-aligned mode, so that it lands at the down-to-up turn. The divider restart is checked right after an observed tick, so that the write edge cannot coincide with a tick from the old configuration.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  localparam int SEL_W  = 3;
  localparam int CTRL_W = SEL_W + 4;

  typedef struct packed {
    logic             center;
    logic             xfer_en;
    logic             run;
    logic             pre_en;
    logic [SEL_W-1:0] sel;
  } ptc_ctrl_t;
endpackage

// File: rtl/ptc_prescale.sv
`timescale 1ns/1ps
module ptc_prescale #(
  parameter int SEL_W    = 3,
  parameter int PRE_LOG2 = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             pre_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1 + PRE_LOG2;
  localparam int SH_W  = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [DIV_W:0]   one_sh;
  logic [SH_W-1:0]  shamt;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      assign shamt = SH_W'(sel_i) + (pre_en_i ? SH_W'(PRE_LOG2) : '0);
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = pre_en_i;
      assign shamt = SH_W'(sel_i);
    end
  endgenerate

  always_comb begin
    one_sh = (DIV_W + 1)'(1) << shamt;
    mask   = DIV_W'(one_sh - (DIV_W + 1)'(1));
  end

  assign tick_o = run_i && (div_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             div_q <= '0;
    else if (!run_i || restart_i || tick_o) div_q <= '0;
    else                                     div_q <= div_q + 1'b1;
  end

  // R3: at a divide ratio above one, ticks never come back to back
  a_r3_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && mask != '0 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/ptc_count.sv
`timescale 1ns/1ps
module ptc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             bound_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  always_comb begin
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    bound_o = 1'b0;
    if (tick_i) begin
      if (!center_i) begin
        dir_d = 1'b0;
        if (cnt_q == per_i) begin
          cnt_d   = '0;
          bound_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (!dir_q) begin
        if (cnt_q == per_i) begin
          if (per_i == '0) begin
            cnt_d   = '0;
            bound_o = 1'b1;
          end else begin
            cnt_d = CNT_W'(per_i - CNT_W'(1));
            dir_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d   = '0;
          dir_d   = 1'b0;
          bound_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(dir_q)));

  a_r5_edge_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !center_i && cnt_q != per_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  a_r6_turn_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && center_i && !dir_q && cnt_q == per_i && per_i > CNT_W'(1)) |=> dir_q);

  a_r6_turn_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && center_i && dir_q && cnt_q == CNT_W'(1)) |=> (!dir_q && cnt_q == '0));
endmodule

// File: rtl/ptc_period.sv
`timescale 1ns/1ps
module ptc_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] per_o
);
  logic [CNT_W-1:0] shadow_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '1;
    else if (wr_i) shadow_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '1;
    else if (xfer_i) act_q <= shadow_q;
  end

  assign per_o = act_q;

  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(act_q));

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (act_q == $past(shadow_q)));
endmodule

// File: rtl/pwm_timer_core.sv
`timescale 1ns/1ps
module pwm_timer_core
  import ptc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              per_wr_i,
  input  logic [CNT_W-1:0]  per_wdata_i,
  output logic [CNT_W-1:0]  per_act_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic              pmatch_o
);
  ptc_ctrl_t ctrl_q, ctrl_new;
  logic      restart, tick, bound, xfer;

  assign ctrl_new = ptc_ctrl_t'(ctrl_wdata_i);
  assign restart  = ctrl_wr_i &&
                    ({ctrl_new.pre_en, ctrl_new.sel} != {ctrl_q.pre_en, ctrl_q.sel});
  assign xfer     = bound && ctrl_q.xfer_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q         <= '0;
    else if (ctrl_wr_i) ctrl_q         <= ctrl_new;
    else if (xfer)      ctrl_q.xfer_en <= 1'b0;
  end

  ptc_prescale #(.SEL_W(SEL_W), .PRE_LOG2(PRE_LOG2)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_q.run),
    .restart_i (restart),
    .pre_en_i  (ctrl_q.pre_en),
    .sel_i     (ctrl_q.sel),
    .tick_o    (tick)
  );

  ptc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .center_i (ctrl_q.center),
    .per_i    (per_act_o),
    .cnt_o    (cnt_o),
    .dir_o    (dir_o),
    .bound_o  (bound)
  );

  ptc_period #(.CNT_W(CNT_W)) u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (per_wr_i),
    .wdata_i (per_wdata_i),
    .xfer_i  (xfer),
    .per_o   (per_act_o)
  );

  assign ctrl_o   = ctrl_q;
  assign pmatch_o = tick && (cnt_o == per_act_o);

  // R9: a transfer with no competing write leaves the enable cleared
  a_r9_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && !ctrl_wr_i) |=> !ctrl_o[4+SEL_W-2]);

  // R4: a stopped timer never flags a match
  a_r4_no_match_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[SEL_W+1] |-> !pmatch_o);
endmodule

// File: tb/pwm_timer_core_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_core_tb_top;
  localparam logic [6:0] RUN = 7'h10, STE = 7'h20, CEN = 7'h40, PRE = 7'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [6:0]  ctrl_wdata = '0;
  logic [6:0]  ctrl_q;
  logic        per_wr = 1'b0;
  logic [15:0] per_wdata = '0;
  logic [15:0] per_act, cnt;
  logic        dir, pmatch;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  int m_div, m_cnt, m_dir, m_per, m_shadow, m_ctrl;

  always #2.5 clk = ~clk;

  pwm_timer_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_o(ctrl_q), .per_wr_i(per_wr), .per_wdata_i(per_wdata),
    .per_act_o(per_act), .cnt_o(cnt), .dir_o(dir), .pmatch_o(pmatch)
  );

  function automatic int divisor(int c);
    return (1 << (c & 7)) * (((c >> 3) & 1) != 0 ? 256 : 1);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_dir = 0; m_per = 16'hFFFF; m_shadow = 16'hFFFF; m_ctrl = 0;
    end else begin
      int  run, tick, rst_div, bnd, xf;
      run     = (m_ctrl >> 4) & 1;
      tick    = (run != 0 && m_div == divisor(m_ctrl) - 1) ? 1 : 0;
      rst_div = (ctrl_wr && ((int'(ctrl_wdata) & 15) != (m_ctrl & 15))) ? 1 : 0;
      bnd     = 0;
      if (tick != 0) begin
        if (((m_ctrl >> 6) & 1) == 0) begin
          m_dir = 0;
          if (m_cnt == m_per) begin m_cnt = 0; bnd = 1; end
          else m_cnt = (m_cnt + 1) & 16'hFFFF;
        end else if (m_dir == 0) begin
          if (m_cnt == m_per) begin
            if (m_per == 0) begin m_cnt = 0; bnd = 1; end
            else begin m_cnt = m_per - 1; m_dir = 1; end
          end else m_cnt = (m_cnt + 1) & 16'hFFFF;
        end else begin
          if (m_cnt <= 1) begin m_cnt = 0; m_dir = 0; bnd = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_div = (run == 0 || rst_div != 0 || tick != 0) ? 0 : m_div + 1;
      xf = (bnd != 0 && ((m_ctrl >> 5) & 1) != 0) ? 1 : 0;
      if (xf != 0) m_per = m_shadow;
      if (ctrl_wr) m_ctrl = int'(ctrl_wdata);
      else if (xf != 0) m_ctrl = m_ctrl & ~32;
      if (per_wr) m_shadow = int'(per_wdata);
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int exp_pm;
      string ctag;
      exp_pm = (((m_ctrl >> 4) & 1) != 0 && m_div == divisor(m_ctrl) - 1 && m_cnt == m_per) ? 1 : 0;
      if (((m_ctrl >> 4) & 1) == 0) ctag = "R4";
      else if (((m_ctrl >> 6) & 1) != 0) ctag = "R6";
      else ctag = "R5";
      chk(ctag, "count", int'(cnt), m_cnt);
      chk("R6", "direction", int'(dir), m_dir);
      chk("R7", "period match", int'(pmatch), exp_pm);
      chk("R8", "active period", int'(per_act), m_per);
      chk("R2,R9", "control readback", int'(ctrl_q), m_ctrl);
    end
  end

  task automatic wr_ctrl(input logic [6:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_shadow(input logic [15:0] v);
    @(negedge clk); per_wr = 1'b1; per_wdata = v;
    @(negedge clk); per_wr = 1'b0;
  endtask

  task automatic wait_change(output int n);
    logic [15:0] prev;
    prev = cnt;
    n = 0;
    do begin @(negedge clk); n++; end while (cnt == prev && n < 2000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "count", int'(cnt), 0);
    chk("R1", "direction", int'(dir), 0);
    chk("R1", "control", int'(ctrl_q), 0);
    chk("R1", "active period", int'(per_act), 16'hFFFF);
    chk("R1", "match", int'(pmatch), 0);
    cmp_on = 1'b1;

    // first transfer needs a full ramp through 0xFFFF
    wr_shadow(16'd5);
    wr_ctrl(RUN | STE);
    n = 0;
    while (per_act != 16'd5 && n < 70000) begin @(negedge clk); n++; end
    chk("R8", "first transfer period", int'(per_act), 5);
    chk("R9", "enable cleared", int'(ctrl_q[5]), 0);
    repeat (20) @(negedge clk);

    // R3: tick spacing
    wr_ctrl(RUN | 7'd2);
    wait_change(n); wait_change(n);
    chk("R3", "ticks at select 2", n, 4);
    wr_ctrl(RUN | PRE);
    wait_change(n); wait_change(n);
    chk("R3", "ticks with extra stage", n, 256);
    wr_ctrl(RUN | 7'd7);
    wait_change(n); wait_change(n);
    chk("R3", "ticks at select 7", n, 128);

    // R10: same config keeps phase, new config restarts
    wr_ctrl(RUN | 7'd7);
    wait_change(n);
    chk("R10", "unchanged config keeps phase", n, 126);
    wr_ctrl(RUN | 7'd1);
    wait_change(n);
    chk("R10", "changed config restarts", n, 2);

    // R4: stop holds
    wr_ctrl(7'd1);
    held = cnt;
    repeat (20) @(negedge clk);
    chk("R4", "held count", int'(cnt), int'(held));

    // R8: no transfer without enable
    wr_shadow(16'd9);
    wr_ctrl(RUN);
    repeat (40) @(negedge clk);
    chk("R8", "period without enable", int'(per_act), 5);

    // R6: center-aligned, then transfer at the turn
    wr_ctrl(RUN | CEN);
    repeat (40) @(negedge clk);
    wr_ctrl(RUN | CEN | STE);
    n = 0;
    while (per_act != 16'd9 && n < 200) begin @(negedge clk); n++; end
    chk("R8", "center transfer period", int'(per_act), 9);
    chk("R9", "enable cleared in center", int'(ctrl_q[5]), 0);
    repeat (60) @(negedge clk);
    while (dir != 1'b1) @(negedge clk);
    wr_ctrl(RUN);
    repeat (30) @(negedge clk);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule